// File: doc/BRIEF.md
# Oversampling Serial Receiver with Consumer Handshake

This block receives asynchronous serial frames on a single line that rests high. An internal integer divider makes a sampling tick at sixteen times the bit rate. The line passes through a resynchronizing flop chain. A small state machine then finds the falling edge of a start bit and confirms the start bit at its middle. After that it samples every following bit once, sixteen ticks apart, so each sample lands near the centre of its bit.

The number of data bits, the parity rule and the stop length are set on configuration pins. The receiver latches them when it detects a start edge. A finished byte goes into a one-entry output buffer together with its parity and framing status, and `rx_ready` rises. The consumer reads `rx_data` and pulses `rx_received`, which clears `rx_ready`. If a new frame finishes before the consumer has acknowledged, the new byte replaces the old one and the overrun flag is set.

Top module: `uart_os_rx`

## Requirements
- R1: The line idles high. A low level seen on a sampling tick starts a frame. The start bit is checked 8 ticks later, and each later bit is sampled every 16 ticks, one sample per bit. The bit time is 16 × CLK_DIV clock cycles.
- R2: If the line is high again at the mid-start check, the event is dropped and the receiver returns to idle. It makes no output change and is ready for the next falling edge.
- R3: Data bits arrive least significant first. `cfg_bits` 0 gives 6 bits, 1 gives 7 bits, and 2 or 3 give 8 bits. Unused upper bits of `rx_data` read 0.
- R4: Parity follows `cfg_par`. Bit 2 = 0 means no parity bit. When bit 2 = 1, bits 1:0 select the rule: 0 = even (data plus parity has an even count of ones), 1 = odd, 2 = parity bit fixed at 0, 3 = parity bit fixed at 1. A mismatch sets `par_err` for that byte.
- R5: `cfg_stop` 0 gives one stop bit, 1 gives one and a half, and 2 or 3 give two. Every stop bit that is sampled must be 1. A sampled 0 sets `frm_err` for that byte, and the byte is still delivered.
- R6: With one and a half stop bits, only the first stop bit is sampled. The receiver then waits 8 more ticks and returns to idle, so a frame that follows right after the half bit is received correctly.
- R7: When a frame completes, `rx_data`, `par_err` and `frm_err` are loaded and `rx_ready` rises. A one-cycle pulse on `rx_received` clears `rx_ready` on the next clock edge.
- R8: If a frame completes while `rx_ready` is set and no acknowledge arrives in the same cycle, the new byte replaces the old one and `overrun` is set. An acknowledge clears `overrun`.
- R9: After reset, `rx_ready`, `rx_data`, `par_err`, `frm_err` and `overrun` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Serial input, idle high |
| cfg_bits | input | 2 | Data bit count select |
| cfg_par | input | 3 | Parity enable and rule |
| cfg_stop | input | 2 | Stop length select |
| rx_received | input | 1 | Consumer acknowledge pulse |
| rx_data | output | 8 | Buffered received byte |
| rx_ready | output | 1 | Buffered byte not yet acknowledged |
| par_err | output | 1 | Parity mismatch on buffered byte |
| frm_err | output | 1 | Stop bit sampled low on buffered byte |
| overrun | output | 1 | Unacknowledged byte was replaced |

## Verification
The bench sends a short low pulse that is not a real start bit. A receiver that skips the mid-start check would assemble a false byte from it and raise `rx_ready`. A frame with one and a half stop bits is followed at once by another frame. A design that waits a full second stop bit would miss that next start edge or read it off-centre. Random frames mix all widths and parity rules, some with a bad parity bit and some with a stop bit held low. This exposes wrong bit ordering, wrong masking of the upper bits, an inverted parity rule, and a second stop bit that is never checked. Two frames sent without an acknowledge must end with the newer byte in the buffer and `overrun` set. A design that kept the old byte, or never set `overrun`, would fail that check.

// File: rtl/uart_os_rx_pkg.sv
package uart_os_rx_pkg;
   typedef enum logic [2:0] {
      RX_IDLE  = 3'd0,
      RX_START = 3'd1,
      RX_DATA  = 3'd2,
      RX_PAR   = 3'd3,
      RX_STOP  = 3'd4,
      RX_HOLD  = 3'd5
   } rx_state_e;

   localparam int OSR       = 16;
   localparam int MID_COUNT = OSR / 2 - 1;
   localparam int END_COUNT = OSR - 1;
endpackage

// File: rtl/uart_os_rx_baud.sv
module uart_os_rx_baud #(
   parameter int CLK_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int CW = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);

   initial begin
      if (CLK_DIV < 2) $error("CLK_DIV must be at least 2");
   end

   logic [CW-1:0] div_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= '0;
         tick  <= 1'b0;
      end else begin
         tick <= (div_q == LAST);
         if (div_q == LAST) div_q <= '0;
         else               div_q <= div_q + 1'b1;
      end
   end

   // R1: ticks are single-cycle pulses, spaced by the divider
   a_r1_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
endmodule

// File: rtl/uart_os_rx_sync.sv
module uart_os_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   initial begin
      if (STAGES < 2) $error("STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   generate
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[0] <= 1'b1;
               else        chain_q[0] <= din;
            end
         end else begin : g_rest
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[g] <= 1'b1;
               else        chain_q[g] <= chain_q[g-1];
            end
         end
      end
   endgenerate

   assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/uart_os_rx_core.sv
module uart_os_rx_core
   import uart_os_rx_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              rxs,
   input  logic [1:0]        cfg_bits,
   input  logic [2:0]        cfg_par,
   input  logic [1:0]        cfg_stop,
   output logic              done,
   output logic [BYTE_W-1:0] dout,
   output logic              perr,
   output logic              ferr
);
   localparam int IW = $clog2(BYTE_W);

   initial begin
      if (BYTE_W != 8) $error("BYTE_W must be 8");
   end

   rx_state_e         st_q;
   logic [3:0]        cnt_q;
   logic [IW-1:0]     idx_q;
   logic [IW-1:0]     last_idx_q;
   logic [BYTE_W-1:0] sh_q;
   logic [2:0]        par_q;
   logic [1:0]        stop_q;
   logic              stop2_q;
   logic              perr_q;
   logic              ferr_q;
   logic              exp_par;
   logic              two_stop;
   logic              f_now;
   logic              at_mid;
   logic              at_end;

   assign at_mid   = (cnt_q == 4'(MID_COUNT));
   assign at_end   = (cnt_q == 4'(END_COUNT));
   assign two_stop = stop_q[1];
   assign f_now    = ferr_q | ~rxs;

   always_comb begin
      unique case (par_q[1:0])
         2'd0:    exp_par = ^sh_q;
         2'd1:    exp_par = ~^sh_q;
         2'd2:    exp_par = 1'b0;
         default: exp_par = 1'b1;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= RX_IDLE;
         cnt_q      <= '0;
         idx_q      <= '0;
         last_idx_q <= '0;
         sh_q       <= '0;
         par_q      <= '0;
         stop_q     <= '0;
         stop2_q    <= 1'b0;
         perr_q     <= 1'b0;
         ferr_q     <= 1'b0;
         done       <= 1'b0;
         dout       <= '0;
         perr       <= 1'b0;
         ferr       <= 1'b0;
      end else begin
         done <= 1'b0;
         if (tick) begin
            unique case (st_q)
               RX_IDLE: begin
                  if (!rxs) begin
                     st_q    <= RX_START;
                     cnt_q   <= '0;
                     sh_q    <= '0;
                     perr_q  <= 1'b0;
                     ferr_q  <= 1'b0;
                     stop2_q <= 1'b0;
                     par_q   <= cfg_par;
                     stop_q  <= cfg_stop;
                     unique case (cfg_bits)
                        2'd0:    last_idx_q <= IW'(5);
                        2'd1:    last_idx_q <= IW'(6);
                        default: last_idx_q <= IW'(7);
                     endcase
                  end
               end
               RX_START: begin
                  if (at_mid) begin
                     cnt_q <= '0;
                     idx_q <= '0;
                     st_q  <= rxs ? RX_IDLE : RX_DATA;
                  end else cnt_q <= cnt_q + 1'b1;
               end
               RX_DATA: begin
                  if (at_end) begin
                     cnt_q       <= '0;
                     sh_q[idx_q] <= rxs;
                     idx_q       <= idx_q + 1'b1;
                     if (idx_q == last_idx_q) st_q <= par_q[2] ? RX_PAR : RX_STOP;
                  end else cnt_q <= cnt_q + 1'b1;
               end
               RX_PAR: begin
                  if (at_end) begin
                     cnt_q  <= '0;
                     perr_q <= (rxs != exp_par);
                     st_q   <= RX_STOP;
                  end else cnt_q <= cnt_q + 1'b1;
               end
               RX_STOP: begin
                  if (at_end) begin
                     cnt_q <= '0;
                     if (two_stop && !stop2_q) begin
                        stop2_q <= 1'b1;
                        ferr_q  <= f_now;
                     end else begin
                        done <= 1'b1;
                        dout <= sh_q;
                        perr <= perr_q;
                        ferr <= f_now;
                        st_q <= (stop_q == 2'd1) ? RX_HOLD : RX_IDLE;
                     end
                  end else cnt_q <= cnt_q + 1'b1;
               end
               RX_HOLD: begin
                  if (at_mid) begin
                     cnt_q <= '0;
                     st_q  <= RX_IDLE;
                  end else cnt_q <= cnt_q + 1'b1;
               end
               default: st_q <= RX_IDLE;
            endcase
         end
      end
   end

   // R2: a high line at the mid-start check sends the receiver back to idle
   a_r2_glitch_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && st_q == RX_START && at_mid && rxs) |=> (st_q == RX_IDLE));

   // R3: the bit index never passes the configured last bit while in data state
   a_r3_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == RX_DATA) |-> (idx_q <= last_idx_q));

   // R6: the half-stop wait is entered only in one-and-a-half stop mode
   a_r6_hold_mode: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == RX_HOLD) |-> (stop_q == 2'd1));

   // R1: a frame only completes on a sampling tick
   a_r1_done_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(tick));
endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx #(
   parameter int CLK_DIV     = 4,
   parameter int SYNC_STAGES = 2,
   parameter int BYTE_W      = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_line,
   input  logic [1:0]        cfg_bits,
   input  logic [2:0]        cfg_par,
   input  logic [1:0]        cfg_stop,
   input  logic              rx_received,
   output logic [BYTE_W-1:0] rx_data,
   output logic              rx_ready,
   output logic              par_err,
   output logic              frm_err,
   output logic              overrun
);
   logic              tick;
   logic              rxs;
   logic              fr_done;
   logic [BYTE_W-1:0] fr_data;
   logic              fr_perr;
   logic              fr_ferr;

   uart_os_rx_baud #(.CLK_DIV(CLK_DIV)) baud_i (
      .clk(clk), .rst_n(rst_n), .tick(tick));

   uart_os_rx_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .din(rx_line), .dout(rxs));

   uart_os_rx_core #(.BYTE_W(BYTE_W)) core_i (
      .clk(clk), .rst_n(rst_n), .tick(tick), .rxs(rxs),
      .cfg_bits(cfg_bits), .cfg_par(cfg_par), .cfg_stop(cfg_stop),
      .done(fr_done), .dout(fr_data), .perr(fr_perr), .ferr(fr_ferr));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_data  <= '0;
         rx_ready <= 1'b0;
         par_err  <= 1'b0;
         frm_err  <= 1'b0;
         overrun  <= 1'b0;
      end else if (fr_done) begin
         rx_data  <= fr_data;
         par_err  <= fr_perr;
         frm_err  <= fr_ferr;
         rx_ready <= 1'b1;
         overrun  <= rx_ready & ~rx_received;
      end else if (rx_received) begin
         rx_ready <= 1'b0;
         overrun  <= 1'b0;
      end
   end

   // R7: an acknowledge with no new frame clears ready
   a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_received && !fr_done) |=> !rx_ready);

   // R7: ready only rises when a frame has completed
   a_r7_ready_source: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_ready) |-> $past(fr_done));

   // R8: a frame landing on an unacknowledged byte flags overrun
   a_r8_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
      (fr_done && rx_ready && !rx_received) |=> (overrun && rx_ready));

   // R8: overrun never stands without a buffered byte
   a_r8_overrun_ready: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |-> rx_ready);
endmodule

// File: tb/uart_os_rx_tb_top.sv
module uart_os_rx_tb_top;
   localparam int DIV  = 4;
   localparam int TICK = DIV;
   localparam int BIT  = 16 * DIV;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_line = 1'b1;
   logic [1:0] cfg_bits = 2'd2;
   logic [2:0] cfg_par = 3'd0;
   logic [1:0] cfg_stop = 2'd0;
   logic       rx_received = 1'b0;
   logic [7:0] rx_data;
   logic       rx_ready, par_err, frm_err, overrun;

   int n_chk = 0;
   int n_fail = 0;
   bit done_flag = 1'b0;

   always #10 clk = ~clk;

   uart_os_rx #(.CLK_DIV(DIV)) dut_i (
      .clk(clk), .rst_n(rst_n), .rx_line(rx_line),
      .cfg_bits(cfg_bits), .cfg_par(cfg_par), .cfg_stop(cfg_stop),
      .rx_received(rx_received), .rx_data(rx_data), .rx_ready(rx_ready),
      .par_err(par_err), .frm_err(frm_err), .overrun(overrun));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int nbits(input logic [1:0] c);
      return (c == 2'd0) ? 6 : (c == 2'd1) ? 7 : 8;
   endfunction

   function automatic logic [7:0] mask_data(input logic [7:0] d, input logic [1:0] c);
      return d & 8'((1 << nbits(c)) - 1);
   endfunction

   function automatic logic par_bit(input logic [7:0] d, input logic [1:0] rule);
      case (rule)
         2'd0:    return ^d;
         2'd1:    return ~^d;
         2'd2:    return 1'b0;
         default: return 1'b1;
      endcase
   endfunction

   task automatic hold(input logic v, input int clocks);
      rx_line = v;
      repeat (clocks) @(negedge clk);
   endtask

   // bad_stop: 0 none, 1 first stop low, 2 second stop low
   task automatic send(input logic [7:0] d, input bit bad_par, input int bad_stop);
      logic [7:0] m;
      m = mask_data(d, cfg_bits);
      hold(1'b0, BIT);
      for (int i = 0; i < nbits(cfg_bits); i++) hold(m[i], BIT);
      if (cfg_par[2]) hold(par_bit(m, cfg_par[1:0]) ^ bad_par, BIT);
      if (bad_stop == 1) begin hold(1'b0, 12 * TICK); hold(1'b1, 4 * TICK); end
      else hold(1'b1, BIT);
      if (cfg_stop == 2'd1) hold(1'b1, BIT / 2);
      else if (cfg_stop[1]) begin
         if (bad_stop == 2) begin hold(1'b0, 12 * TICK); hold(1'b1, 4 * TICK); end
         else hold(1'b1, BIT);
      end
      rx_line = 1'b1;
   endtask

   task automatic ack();
      rx_received = 1'b1;
      @(negedge clk);
      rx_received = 1'b0;
   endtask

   task automatic expect_frame(input logic [7:0] d, input bit pe, input bit fe, input string req);
      chk(rx_ready === 1'b1, {req, " ready"}, rx_ready, 1);
      chk(rx_data === mask_data(d, cfg_bits), {req, " data"}, rx_data, mask_data(d, cfg_bits));
      chk(par_err === pe, {req, " par_err"}, par_err, pe);
      chk(frm_err === fe, {req, " frm_err"}, frm_err, fe);
      chk(overrun === 1'b0, {req, " overrun"}, overrun, 0);
      ack();
      chk(rx_ready === 1'b0, "R7 ack clears ready", rx_ready, 0);
   endtask

   initial begin
      int unused_seed;
      unused_seed = $urandom(32'h5EED_0042);
      repeat (5) @(negedge clk);
      chk(rx_ready === 1'b0 && rx_data === 8'h00, "R9 reset ready/data", {rx_ready, rx_data}, 0);
      chk(par_err === 1'b0 && frm_err === 1'b0 && overrun === 1'b0, "R9 reset flags",
          {par_err, frm_err, overrun}, 0);
      rst_n = 1'b1;
      hold(1'b1, 2 * BIT);

      // R1, R3: plain 8N1 frame
      cfg_bits = 2'd2; cfg_par = 3'd0; cfg_stop = 2'd0;
      send(8'hA5, 1'b0, 0); repeat (4) @(negedge clk);
      expect_frame(8'hA5, 1'b0, 1'b0, "R1 R3 8N1");
      hold(1'b1, BIT);

      // R2: short low pulse must not produce a byte
      hold(1'b0, 4 * TICK); hold(1'b1, 3 * BIT);
      chk(rx_ready === 1'b0, "R2 glitch ignored", rx_ready, 0);
      send(8'h3C, 1'b0, 0); repeat (4) @(negedge clk);
      expect_frame(8'h3C, 1'b0, 1'b0, "R2 frame after glitch");
      hold(1'b1, BIT);

      // R3: 6-bit frame with upper data bits set in the source
      cfg_bits = 2'd0;
      send(8'hFF, 1'b0, 0); repeat (4) @(negedge clk);
      expect_frame(8'hFF, 1'b0, 1'b0, "R3 six bits");
      hold(1'b1, BIT);

      // R4: odd parity, bad parity bit
      cfg_bits = 2'd2; cfg_par = 3'b101;
      send(8'h81, 1'b1, 0); repeat (4) @(negedge clk);
      expect_frame(8'h81, 1'b1, 1'b0, "R4 odd bad");
      hold(1'b1, BIT);

      // R5: two stop bits, second one low
      cfg_par = 3'b100; cfg_stop = 2'd2;
      send(8'h5A, 1'b0, 2); repeat (4) @(negedge clk);
      expect_frame(8'h5A, 1'b0, 1'b1, "R5 second stop low");
      hold(1'b1, 2 * BIT);

      // R6: one and a half stops, next frame follows at once
      cfg_par = 3'd0; cfg_stop = 2'd1;
      send(8'hC3, 1'b0, 0);
      expect_frame(8'hC3, 1'b0, 1'b0, "R6 first of pair");
      send(8'h19, 1'b0, 0); repeat (4) @(negedge clk);
      expect_frame(8'h19, 1'b0, 1'b0, "R6 back to back");
      hold(1'b1, BIT);

      // R8: two frames without acknowledge
      cfg_stop = 2'd0;
      send(8'h11, 1'b0, 0); hold(1'b1, BIT);
      send(8'h22, 1'b0, 0); repeat (4) @(negedge clk);
      chk(rx_ready === 1'b1 && overrun === 1'b1, "R8 overrun flagged", {rx_ready, overrun}, 3);
      chk(rx_data === 8'h22, "R8 newer byte kept", rx_data, 8'h22);
      ack();
      chk(overrun === 1'b0 && rx_ready === 1'b0, "R8 ack clears overrun", {rx_ready, overrun}, 0);
      hold(1'b1, BIT);

      // R1 R3 R4 R5 R6: random mix
      for (int k = 0; k < 70; k++) begin
         logic [7:0] d;
         bit bp;
         int bs;
         d = 8'($urandom);
         cfg_bits = 2'($urandom);
         cfg_par = 3'($urandom);
         cfg_stop = 2'($urandom);
         bp = cfg_par[2] && ($urandom % 4 == 0);
         bs = ($urandom % 5 == 0) ? ((cfg_stop[1] && $urandom % 2) ? 2 : 1) : 0;
         send(d, bp, bs); repeat (4) @(negedge clk);
         expect_frame(d, bp, bs != 0, "R4 R5 random");
         hold(1'b1, 2 * BIT);
      end

      done_flag = 1'b1;
   end

   initial begin
      int cyc;
      cyc = 0;
      while (!done_flag && cyc < 190000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done_flag) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      end
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule